// File: doc/BRIEF.md
# Dual-Channel Pulse Width Qualifier

This block sits between two active-low request lines and a processor core. One line requests a core reset. The other carries a non-maskable interrupt request; in this configuration the watchdog timer raises it. The block lets a request through only when the request has stayed low for a minimum number of system clock cycles, 16 by default. Shorter low pulses are treated as glitches and never reach the core. Each raw line is first brought into the clock domain by a two-stage synchronizer. A saturating counter then measures how long the synchronized line has been low.

A one-byte control register sits at a single bus address. It holds one enable bit per channel. Clearing a channel's bit puts that channel in bypass, so the synchronized input goes to the output with no width check. Both bits come out of reset set, so both filters start out active. The threshold is counted in cycles of whatever system clock is running, so the length in time scales with that clock. All filter state and the register are cleared by the bus reset, never by the filtered reset output.

Top module: `pulse_gate_pair`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, both outputs are high and the control register reads 0x03. This holds even if a raw input is low at that time.
- R2: With the channel's enable bit set, a raw low pulse of 1 to 15 cycles never drives that channel's output low.
- R3: With the enable bit set, a raw low pulse of W ≥ 16 cycles drives the output low. Number the first rising edge that samples the input low as edge 0. The output goes low after edge 17 and stays low for W−15 cycles.
- R4: With the enable bit clear, a raw low pulse of any width W ≥ 1 drives the output low after edge 2 (same edge numbering) for exactly W cycles.
- R5: Register bit 1 enables filtering on the reset channel and bit 0 on the interrupt channel, with 1 meaning filter and 0 meaning bypass. Activity on one channel never moves the other channel's output.
- R6: Register bits 7 to 2 always read 0, and writing ones to them changes nothing. Writing 0xFC reads back as 0x00, and writing 0xFF reads back as 0x03.
- R7: `bus_rdata` is 0 unless `bus_sel` is high and `bus_addr` equals `CTRL_ADDR`. A write to any other address leaves the enable bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high bus reset |
| bus_addr | input | ADDR_W | Register address |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable, qualified by `bus_sel` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| raw_rst_n | input | 1 | Asynchronous active-low reset request |
| raw_nmi_n | input | 1 | Asynchronous active-low interrupt request |
| core_rst_n | output | 1 | Qualified active-low reset to the core |
| core_nmi_n | output | 1 | Qualified active-low interrupt to the core |

## Verification
The assertions take three things for granted about the inputs:
- `rst` is high from time zero, so every history they look at begins at a known reset state.
- The raw request lines never change close to a rising clock edge. This is what makes the synchronizer delay exactly two cycles and makes the bypass-delay and minimum-width properties exact.
- A mode change never lands in the middle of a pulse that the minimum-width property judges.

The bench keeps within these assumptions. It drives every input on the falling edge and holds reset from the start. It changes the enable bits only while both lines are idle, and it lets each pulse drain for 25 cycles before the next begins.

// File: rtl/pnf_pkg.sv
package pnf_pkg;
  localparam int NUM_CH   = 2;
  localparam int DATA_W   = 8;
  localparam int CH_NMI   = 0;
  localparam int CH_RST   = 1;
  localparam logic [NUM_CH-1:0] EN_RESET = '1;
endpackage

// File: rtl/pnf_sync.sv
module pnf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_n};
  end

  assign q_n = chain[STAGES-1];
endmodule

// File: rtl/pnf_width_gate.sv
module pnf_width_gate #(
  parameter int MIN_WIDTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_n,
  input  logic filt_en,
  output logic out_n
);
  localparam int CNT_W = $clog2(MIN_WIDTH + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_WIDTH);
  localparam logic [CNT_W-1:0] NEAR  = CNT_W'(MIN_WIDTH - 1);

  logic             sync_n;
  logic             active;
  logic             reach;
  logic [CNT_W-1:0] cnt;

  pnf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_n (raw_n),
    .q_n (sync_n)
  );

  assign active = ~sync_n;
  // next counter value will sit at the threshold
  assign reach  = active && (cnt >= NEAR);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (!active)     cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          out_n <= 1'b1;
    else if (filt_en) out_n <= ~reach;
    else              out_n <= sync_n;
  end
endmodule

// File: rtl/pnf_ctrl_reg.sv
module pnf_ctrl_reg
  import pnf_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] en
);
  logic hit;
  wire  unused_reserved_wr = ^bus_wdata[DATA_W-1:NUM_CH];

  assign hit = bus_sel && (bus_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst)               en <= EN_RESET;
    else if (hit && bus_we) en <= bus_wdata[NUM_CH-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) bus_rdata[NUM_CH-1:0] = en;
  end
endmodule

// File: rtl/pulse_gate_pair.sv
module pulse_gate_pair
  import pnf_pkg::*;
#(
  parameter int               MIN_WIDTH   = 16,
  parameter int               SYNC_STAGES = 2,
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              raw_rst_n,
  input  logic              raw_nmi_n,
  output logic              core_rst_n,
  output logic              core_nmi_n
);
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] gated_n;

  assign raw_vec[CH_RST] = raw_rst_n;
  assign raw_vec[CH_NMI] = raw_nmi_n;

  pnf_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .en        (ch_en)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pnf_width_gate #(.MIN_WIDTH(MIN_WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk     (clk),
      .rst     (rst),
      .raw_n   (raw_vec[ch]),
      .filt_en (ch_en[ch]),
      .out_n   (gated_n[ch])
    );
  end

  assign core_rst_n = gated_n[CH_RST];
  assign core_nmi_n = gated_n[CH_NMI];
endmodule

// File: rtl/pulse_gate_pair_chk.sv
module pulse_gate_pair_chk #(
  parameter int               MIN_WIDTH = 16,
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        raw_n,
  input logic [1:0]        out_n,
  input logic [1:0]        en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        wlow,
  input logic [7:0]        bus_rdata
);
  localparam int CW = $clog2(MIN_WIDTH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_WIDTH);

  logic [1:0] age;
  logic       hit;
  assign hit = bus_sel && (bus_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_n == 2'b11) && (en == 2'b11));

  // R5
  en_write_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && bus_we) |=> (en == $past(wlow)));

  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(hit && bus_we) |=> $stable(en));

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (bus_rdata == 8'h00));

  for (genvar c = 0; c < 2; c++) begin : g_c
    logic [CW-1:0] run;
    logic [CW-1:0] peak;
    logic [CW-1:0] run_nx;
    assign run_nx = (run != LIMIT) ? run + 1'b1 : run;

    always_ff @(posedge clk) begin
      if (rst) begin
        run  <= '0;
        peak <= '0;
      end else if (!raw_n[c]) begin
        run  <= run_nx;
        peak <= run_nx;
      end else begin
        run  <= '0;
      end
    end

    // R2
    min_width_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(out_n[c]) && $past(en[c])) |-> (peak >= LIMIT));

    // R4
    bypass_delay_chk: assert property (@(posedge clk) disable iff (rst)
      ((age == 2'd3) && !$past(en[c])) |-> (out_n[c] == $past(raw_n[c], 3)));
  end
endmodule

bind pulse_gate_pair pulse_gate_pair_chk #(
  .MIN_WIDTH (MIN_WIDTH),
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .raw_n     (raw_vec),
  .out_n     (gated_n),
  .en        (ch_en),
  .bus_addr  (bus_addr),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .wlow      (bus_wdata[1:0]),
  .bus_rdata (bus_rdata)
);

// File: tb/tb_pulse_gate_pair.sv
`timescale 1ns/1ps
module tb_pulse_gate_pair;
  localparam logic [7:0] CTRL = 8'h40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] raw = 2'b11;   // index 1 reset channel, 0 interrupt channel
  logic [1:0] outs;
  logic       core_rst_n, core_nmi_n;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pulse_gate_pair dut (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .raw_rst_n  (raw[1]),
    .raw_nmi_n  (raw[0]),
    .core_rst_n (core_rst_n),
    .core_nmi_n (core_nmi_n)
  );

  assign outs = {core_rst_n, core_nmi_n};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_we = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, input bit sel, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_sel = sel; bus_we = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // edge 0 = first rising edge that samples the input low
  task automatic run_pulse(input int ch, input int w, input bit filt);
    int    oth = 1 - ch;
    string tag;
    tag = filt ? ((w < 16) ? "R2" : "R3") : "R4";
    @(negedge clk);
    raw[ch] = 1'b0;
    for (int n = 1; n <= w + 25; n++) begin
      int e = n - 1;
      bit lo;
      @(posedge clk);
      @(negedge clk);
      lo = filt ? (w >= 16 && e >= 17 && e <= w + 1) : (e >= 2 && e <= w + 1);
      check(outs[ch] == !lo, tag, outs[ch], !lo);
      check(outs[oth] == 1'b1, "R5", outs[oth], 1);
      if (n == w) raw[ch] = 1'b1;
    end
  endtask

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    // R1: state while reset is held, with a raw line low
    raw[1] = 1'b0;
    repeat (3) @(negedge clk);
    check(outs == 2'b11, "R1", outs, 3);
    rst = 1'b0;
    @(negedge clk);
    check(outs == 2'b11, "R1", outs, 3);
    raw[1] = 1'b1;
    reg_read(CTRL, 1'b1, rd);
    check(rd == 8'h03, "R1", rd, 8'h03);
    repeat (25) @(negedge clk);

    // R6 reserved bits
    reg_write(CTRL, 8'hFC);
    reg_read(CTRL, 1'b1, rd);
    check(rd == 8'h00, "R6", rd, 8'h00);
    reg_write(CTRL, 8'hFF);
    reg_read(CTRL, 1'b1, rd);
    check(rd == 8'h03, "R6", rd, 8'h03);

    // R7 decoding
    reg_write(CTRL + 8'h1, 8'h00);
    reg_read(CTRL, 1'b1, rd);
    check(rd == 8'h03, "R7", rd, 8'h03);
    reg_read(CTRL + 8'h1, 1'b1, rd);
    check(rd == 8'h00, "R7", rd, 8'h00);
    reg_read(CTRL, 1'b0, rd);
    check(rd == 8'h00, "R7", rd, 8'h00);

    // R2 R3 R4 R5: sweep every mode pair, both channels, widths 1..20
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic [7:0] c8 = 8'(3 - cfg);
      reg_write(CTRL, c8);
      reg_read(CTRL, 1'b1, rd);
      check(rd == c8, "R5", rd, c8);
      for (int ch = 0; ch < 2; ch++)
        for (int w = 1; w <= 20; w++)
          run_pulse(ch, w, c8[ch]);
    end

    // R1: bus reset in the middle of a long pulse in bypass
    reg_write(CTRL, 8'h00);
    @(negedge clk);
    raw[1] = 1'b0;
    repeat (6) @(negedge clk);
    check(core_rst_n == 1'b0, "R4", core_rst_n, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outs == 2'b11, "R1", outs, 3);
    raw[1] = 1'b1;
    reg_read(CTRL, 1'b1, rd);
    check(rd == 8'h03, "R1", rd, 8'h03);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule